// File: doc/BRIEF.md
# BCD Century Calendar Counter

This block keeps time and date in packed BCD. Each cycle in which the one-second strobe is high and the run enable is set, the seconds advance by one. Carries ripple through minutes, hours (24-hour form), day of week, date, month, year and a two-digit century. The date wraps according to the length of the current month. February gets a 29th day in leap years.

Software or a host block sets the time with a single-cycle parallel load of all eight fields. A load takes precedence over a strobe that arrives in the same cycle. The run enable freezes the chain without losing the loaded values. The oscillator and the divider that produce the one-second strobe live outside this block.

Top module: `bcd_calendar`

## Requirements
- R1: After an active-low reset the fields read century 00, year 00, month 01, date 01, day of week 01, and time 00:00:00.
- R2: When `load` is high at a clock edge, every field takes its `ld_*` value at that edge, even if `tick` and `run` are also high.
- R3: The seconds advance by one BCD step (09 goes to 10) at an edge where `tick` and `run` are both high and `load` is low. With `run` low or `tick` low, no field changes.
- R4: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R5: Hours wrap from 23 to 00. That same carry advances both the day of week and the date.
- R6: The day of week counts 01 to 07 and then returns to 01.
- R7: Months 01, 03, 05, 07, 08, 10 and 12 end after date 31. Months 04, 06, 09 and 11 end after date 30. At the end of a month the date returns to 01 and the month advances.
- R8: February ends after date 29 when the BCD year is divisible by four, including year 00. Otherwise it ends after date 28. The test uses the BCD digits directly: an even tens digit with units 0, 4 or 8, or an odd tens digit with units 2 or 6.
- R9: The month wraps from 12 to 01 and carries into the year.
- R10: The year wraps from 99 to 00 and carries into the century. The century wraps from 39 to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second strobe, one cycle wide |
| run | input | 1 | Counting enable |
| load | input | 1 | Parallel load of all fields |
| ld_sec | input | 8 | Seconds value to load, BCD |
| ld_min | input | 8 | Minutes value to load, BCD |
| ld_hour | input | 8 | Hours value to load, BCD 00-23 |
| ld_dow | input | 8 | Day of week value to load, 01-07 |
| ld_date | input | 8 | Date value to load, BCD |
| ld_month | input | 8 | Month value to load, BCD 01-12 |
| ld_year | input | 8 | Year value to load, BCD |
| ld_cent | input | 8 | Century value to load, BCD 00-39 |
| sec | output | 8 | Seconds |
| min | output | 8 | Minutes |
| hour | output | 8 | Hours |
| dow | output | 8 | Day of week |
| date | output | 8 | Date |
| month | output | 8 | Month |
| year | output | 8 | Year |
| cent | output | 8 | Century |

## Verification
The hardest cases to reach are the month-end and century-end carries. Counting up to them one second at a time would take years of strobes. The bench instead uses the parallel load to place the chain one second before each boundary: 23:59:59 on the last day of a month, on February 28 of leap and non-leap years, and on December 31 of year 99 with centuries 20 and 39. A single strobe then exercises the whole carry path. The February cases cover years 00, 10, 12, 23 and 24, so that both the even-tens and the odd-tens branches of the leap test are taken.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter logic [7:0] CENT_LAST = 8'h39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_cent,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [7:0] cent
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic       step, leap;
  logic       sec_w, min_w, hour_w, date_w, mon_w, year_w;
  logic       c_min, c_hour, c_day, c_mon, c_year, c_cent;
  logic [7:0] last_day;

  assign step   = tick & run;
  assign sec_w  = (sec == 8'h59);
  assign min_w  = (min == 8'h59);
  assign hour_w = (hour == 8'h23);
  assign date_w = (date == last_day);
  assign mon_w  = (month == 8'h12);
  assign year_w = (year == 8'h99);

  assign c_min  = step & sec_w;
  assign c_hour = c_min & min_w;
  assign c_day  = c_hour & hour_w;
  assign c_mon  = c_day & date_w;
  assign c_year = c_mon & mon_w;
  assign c_cent = c_year & year_w;

  // divisible by four, read straight from the two BCD digits
  assign leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                        : (year[3:0] == 4'd0 || year[3:0] == 4'd4 || year[3:0] == 4'd8);

  always_comb begin
    case (month)
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      default:                    last_day = 8'h31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec   <= 8'h00;
      min   <= 8'h00;
      hour  <= 8'h00;
      dow   <= 8'h01;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
      cent  <= 8'h00;
    end else if (load) begin
      sec   <= ld_sec;
      min   <= ld_min;
      hour  <= ld_hour;
      dow   <= ld_dow;
      date  <= ld_date;
      month <= ld_month;
      year  <= ld_year;
      cent  <= ld_cent;
    end else begin
      if (step)   sec   <= sec_w  ? 8'h00 : bcd_inc(sec);
      if (c_min)  min   <= min_w  ? 8'h00 : bcd_inc(min);
      if (c_hour) hour  <= hour_w ? 8'h00 : bcd_inc(hour);
      if (c_day) begin
        dow  <= (dow == 8'h07) ? 8'h01 : bcd_inc(dow);
        date <= date_w ? 8'h01 : bcd_inc(date);
      end
      if (c_mon)  month <= mon_w  ? 8'h01 : bcd_inc(month);
      if (c_year) year  <= year_w ? 8'h00 : bcd_inc(year);
      if (c_cent) cent  <= (cent == CENT_LAST) ? 8'h00 : bcd_inc(cent);
    end
  end

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       run,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_min,
  input logic [7:0] ld_hour,
  input logic [7:0] ld_dow,
  input logic [7:0] ld_date,
  input logic [7:0] ld_month,
  input logic [7:0] ld_year,
  input logic [7:0] ld_cent,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] dow,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic [7:0] cent
);

  logic [63:0] cur, ld;
  assign cur = {cent, year, month, date, dow, hour, min, sec};
  assign ld  = {ld_cent, ld_year, ld_month, ld_date, ld_dow, ld_hour, ld_min, ld_sec};

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(ld));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && run)) |=> $stable(cur));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && run && sec == 8'h59) |=> (sec == 8'h00 && min != $past(min)));

  assert_day_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && run && sec == 8'h59 && min == 8'h59 && hour == 8'h23)
      |=> (hour == 8'h00 && dow != $past(dow) && date != $past(date)));

  assert_dow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (dow >= 8'h01 && dow <= 8'h07));

endmodule

bind bcd_calendar bcd_calendar_chk chk_i (.*);

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, load = 1'b0;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_dow = '0;
  logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0, ld_cent = '0;
  logic [7:0] sec, min, hour, dow, date, month, year, cent;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_calendar dut_i (.*);

  // packed order: century, year, month, date, day of week, hour, minute, second
  task automatic check(input string tag, input logic [63:0] exp);
    logic [63:0] act;
    act = {cent, year, month, date, dow, hour, min, sec};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_all(input logic [63:0] v, input logic with_tick);
    @(negedge clk);
    {ld_cent, ld_year, ld_month, ld_date, ld_dow, ld_hour, ld_min, ld_sec} = v;
    load = 1'b1; tick = with_tick; run = 1'b1;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
  endtask

  task automatic one_tick(input logic r);
    @(negedge clk);
    tick = 1'b1; run = r;
    @(negedge clk);
    tick = 1'b0; run = 1'b1;
  endtask

  task automatic step_from(input string tag, input logic [63:0] start, input logic [63:0] exp);
    set_all(start, 1'b0);
    one_tick(1'b1);
    check(tag, exp);
  endtask

  task automatic test_reset_r1();
    check("R1 reset", 64'h00_00_01_01_01_00_00_00);
  endtask

  task automatic test_load_r2();
    set_all(64'h20_24_02_28_03_23_59_59, 1'b0);
    check("R2 load", 64'h20_24_02_28_03_23_59_59);
    set_all(64'h21_05_07_15_02_12_34_56, 1'b1);
    check("R2 load beats tick", 64'h21_05_07_15_02_12_34_56);
  endtask

  task automatic test_run_r3();
    set_all(64'h20_01_01_01_01_00_00_09, 1'b0);
    one_tick(1'b0);
    check("R3 run low holds", 64'h20_01_01_01_01_00_00_09);
    @(negedge clk); @(negedge clk);
    check("R3 no tick holds", 64'h20_01_01_01_01_00_00_09);
    one_tick(1'b1);
    check("R3 bcd step 09->10", 64'h20_01_01_01_01_00_00_10);
  endtask

  task automatic test_time_r4();
    step_from("R4 sec carry", 64'h20_01_01_01_01_00_00_59, 64'h20_01_01_01_01_00_01_00);
    step_from("R4 min carry", 64'h20_01_01_01_01_09_59_59, 64'h20_01_01_01_01_10_00_00);
  endtask

  task automatic test_day_r5_r6();
    step_from("R5 midnight", 64'h20_01_01_14_03_23_59_59, 64'h20_01_01_15_04_00_00_00);
    step_from("R6 dow wrap", 64'h20_01_01_14_07_23_59_59, 64'h20_01_01_15_01_00_00_00);
  endtask

  task automatic test_months_r7();
    step_from("R7 april 30", 64'h20_01_04_30_01_23_59_59, 64'h20_01_05_01_02_00_00_00);
    step_from("R7 january 30", 64'h20_01_01_30_01_23_59_59, 64'h20_01_01_31_02_00_00_00);
    step_from("R7 october 31", 64'h20_01_10_31_01_23_59_59, 64'h20_01_11_01_02_00_00_00);
  endtask

  task automatic test_leap_r8();
    step_from("R8 year 24 leap", 64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_00_00_00);
    step_from("R8 year 23 common", 64'h20_23_02_28_03_23_59_59, 64'h20_23_03_01_04_00_00_00);
    step_from("R8 year 00 leap", 64'h21_00_02_28_03_23_59_59, 64'h21_00_02_29_04_00_00_00);
    step_from("R8 year 12 leap", 64'h20_12_02_28_03_23_59_59, 64'h20_12_02_29_04_00_00_00);
    step_from("R8 year 10 common", 64'h20_10_02_28_03_23_59_59, 64'h20_10_03_01_04_00_00_00);
    step_from("R8 feb 29 end", 64'h20_24_02_29_03_23_59_59, 64'h20_24_03_01_04_00_00_00);
  endtask

  task automatic test_year_r9_r10();
    step_from("R9 year carry", 64'h20_24_12_31_05_23_59_59, 64'h20_25_01_01_06_00_00_00);
    step_from("R10 century carry", 64'h20_99_12_31_05_23_59_59, 64'h21_00_01_01_06_00_00_00);
    step_from("R10 century wrap", 64'h39_99_12_31_05_23_59_59, 64'h00_00_01_01_06_00_00_00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset_r1();
    test_load_r2();
    test_run_r3();
    test_time_r4();
    test_day_r5_r6();
    test_months_r7();
    test_leap_r8();
    test_year_r9_r10();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule